// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner for a 64-bit Core

This unit sits between a 64-bit memory data path and the integer register file of a 64-bit RISC-V style core. On loads it picks the addressed bytes out of an 8-byte read word. It moves them down to bit 0 and extends them to 64 bits. Byte, halfword and word loads each come in a sign-extending and a zero-extending form. A doubleword load returns all 8 bytes unchanged.

On stores the same address and size inputs produce an 8-bit byte-enable mask. The low bytes of the store data are copied into every lane, so the memory only has to honour the enables.

The unit is purely combinational. An access that is not naturally aligned raises a flag and produces no byte enables. Trap handling is left to the surrounding pipeline.

Top module: `lane_align_unit`

## Requirements
- R1: Byte access (size code 0) at any offset 0..7: the load result is read byte number `offset`. It is sign-extended from its bit 7 when `zero_ext`=0 and zero-extended when `zero_ext`=1.
- R2: Halfword access (size code 1) at an even offset: the load result is bytes `offset` and `offset+1` as a 16-bit value, with the lower-numbered byte least significant. It is sign-extended from bit 15 when `zero_ext`=0 and zero-extended when `zero_ext`=1.
- R3: Word access (size code 2) at offset 0 or 4 with `zero_ext`=0: the load result is the 32-bit value at that offset, sign-extended from bit 31 to 64 bits.
- R4: Word access at offset 0 or 4 with `zero_ext`=1: the load result is the same 32-bit value with the upper 32 bits zero.
- R5: Doubleword access (size code 3) at offset 0: the load result equals the read word for either value of `zero_ext`.
- R6: `misaligned` is 1 exactly when a halfword has an odd offset, a word has an offset other than 0 or 4, or a doubleword has a nonzero offset. Byte accesses are never misaligned.
- R7: While `misaligned` is 1, `byte_en` is 8'h00 and `load_result` is zero.
- R8: For an aligned access, `byte_en` has 1, 2, 4 or 8 contiguous bits set for size code 0, 1, 2 or 3, with the lowest set bit at position `offset`.
- R9: `store_lanes` holds the low 8, 16 or 32 bits of `store_data` repeated 8, 4 or 2 times for size codes 0, 1 and 2. For size code 3 it is `store_data` itself, independent of the offset.
- R10: All outputs follow input changes within the same time step, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| read_word | input | 64 | Data word returned by the memory read |
| offset | input | 3 | Low three address bits (byte offset within the word) |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| zero_ext | input | 1 | 1 selects zero extension, 0 sign extension (ignored for doubleword) |
| store_data | input | 64 | Register value to be written on a store |
| load_result | output | 64 | Aligned and extended register write-back value |
| byte_en | output | 8 | Byte-enable mask for the addressed bytes |
| store_lanes | output | 64 | Store data replicated across byte lanes |
| misaligned | output | 1 | Access offset violates natural alignment |

## Verification
The unit has no stored state, so every fault shows up at the ports in the same time step as the input that triggers it. A wrong lane selection appears as a wrong low byte of `load_result`. A wrong extension rule shows as upper bits that differ from the expected copies of the sign bit or zeros. A faulty alignment decode shows either as an enable mask that is not empty alongside a raised flag, or as a misplaced run of enable bits. Random vectors cover all 64 combinations of size, offset and extension mode many times over. Directed vectors place sign bits at 1 so that the two extension forms give different results.

// File: rtl/lane_align_unit.sv
module lane_align_unit (
  input  logic [63:0] read_word,
  input  logic [2:0]  offset,
  input  logic [1:0]  size,
  input  logic        zero_ext,
  input  logic [63:0] store_data,
  output logic [63:0] load_result,
  output logic [7:0]  byte_en,
  output logic [63:0] store_lanes,
  output logic        misaligned
);
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [1:0] SZ_D = 2'd3;

  logic [63:0] shifted;
  logic [7:0]  base_mask;
  logic [63:0] extended;

  assign shifted = read_word >> {offset, 3'b000};

  always_comb begin
    case (size)
      SZ_B:    misaligned = 1'b0;
      SZ_H:    misaligned = offset[0];
      SZ_W:    misaligned = |offset[1:0];
      default: misaligned = |offset;
    endcase
  end

  always_comb begin
    case (size)
      SZ_B:    base_mask = 8'h01;
      SZ_H:    base_mask = 8'h03;
      SZ_W:    base_mask = 8'h0F;
      default: base_mask = 8'hFF;
    endcase
  end

  assign byte_en = misaligned ? 8'h00 : (base_mask << offset);

  always_comb begin
    case (size)
      SZ_B:    extended = {{56{shifted[7]  & ~zero_ext}}, shifted[7:0]};
      SZ_H:    extended = {{48{shifted[15] & ~zero_ext}}, shifted[15:0]};
      SZ_W:    extended = {{32{shifted[31] & ~zero_ext}}, shifted[31:0]};
      default: extended = shifted;
    endcase
  end

  assign load_result = misaligned ? 64'd0 : extended;

  always_comb begin
    case (size)
      SZ_B:    store_lanes = {8{store_data[7:0]}};
      SZ_H:    store_lanes = {4{store_data[15:0]}};
      SZ_W:    store_lanes = {2{store_data[31:0]}};
      default: store_lanes = store_data;
    endcase
  end
endmodule

// File: rtl/lane_align_checker.sv
module lane_align_checker (
  input logic [63:0] read_word,
  input logic [2:0]  offset,
  input logic [1:0]  size,
  input logic        zero_ext,
  input logic [63:0] store_data,
  input logic [63:0] load_result,
  input logic [7:0]  byte_en,
  input logic [63:0] store_lanes,
  input logic        misaligned
);
  always_comb begin
    if (!$isunknown({offset, size, zero_ext, read_word, store_data})) begin
      if (misaligned)
        assert_quiet_on_misalign_R7: assert (byte_en == 8'h00 && load_result == 64'd0);
      if (!misaligned)
        assert_enable_count_R8: assert ($countones(byte_en) == (1 << size) && byte_en[offset]);
      if (size == 2'd0)
        assert_byte_never_misaligned_R6: assert (!misaligned);
      if (size == 2'd2 && !zero_ext && !misaligned)
        assert_word_sign_fill_R3: assert (load_result[63:32] == {32{load_result[31]}});
      if (size == 2'd2 && zero_ext && !misaligned)
        assert_word_zero_fill_R4: assert (load_result[63:32] == 32'd0);
      if (size == 2'd3 && !misaligned)
        assert_dword_passthru_R5: assert (load_result == read_word && byte_en == 8'hFF);
      if (size == 2'd0)
        assert_byte_replicated_R9: assert (store_lanes[63:56] == store_data[7:0] && store_lanes[31:24] == store_data[7:0]);
      if (size == 2'd3)
        assert_dword_store_R9: assert (store_lanes == store_data);
    end
  end
endmodule

bind lane_align_unit lane_align_checker u_checker (
  .read_word(read_word), .offset(offset), .size(size), .zero_ext(zero_ext),
  .store_data(store_data), .load_result(load_result), .byte_en(byte_en),
  .store_lanes(store_lanes), .misaligned(misaligned)
);

// File: tb/lane_align_unit_tb.sv
module lane_align_unit_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic [63:0] read_word = '0;
  logic [2:0]  offset = '0;
  logic [1:0]  size = '0;
  logic        zero_ext = 1'b0;
  logic [63:0] store_data = '0;
  logic [63:0] load_result;
  logic [7:0]  byte_en;
  logic [63:0] store_lanes;
  logic        misaligned;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  lane_align_unit u_dut (
    .read_word(read_word), .offset(offset), .size(size), .zero_ext(zero_ext),
    .store_data(store_data), .load_result(load_result), .byte_en(byte_en),
    .store_lanes(store_lanes), .misaligned(misaligned)
  );

  function automatic bit exp_mis(input logic [1:0] s, input logic [2:0] o);
    int n = 1 << s;
    return (int'(o) % n) != 0;
  endfunction

  function automatic logic [63:0] exp_load(input logic [63:0] rw, input logic [1:0] s,
                                           input logic [2:0] o, input logic z);
    logic [63:0] v = '0;
    int n = 1 << s;
    if (exp_mis(s, o)) return 64'd0;
    for (int i = 0; i < n; i++) v[i*8 +: 8] = rw[(int'(o) + i)*8 +: 8];
    if (n < 8 && !z && v[n*8-1])
      for (int j = n*8; j < 64; j++) v[j] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] exp_be(input logic [1:0] s, input logic [2:0] o);
    logic [7:0] m = '0;
    if (exp_mis(s, o)) return 8'h00;
    for (int i = 0; i < (1 << s); i++) m[int'(o) + i] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] exp_st(input logic [63:0] d, input logic [1:0] s);
    logic [63:0] v;
    int n = 1 << s;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = d[(i % n)*8 +: 8];
    return v;
  endfunction

  function automatic string tag_of(input logic [1:0] s, input logic z, input bit mis);
    if (mis) return "R7";
    case (s)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return z ? "R4" : "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic [63:0] rw, input logic [1:0] s, input logic [2:0] o,
                       input logic z, input logic [63:0] sd);
    bit m;
    read_word = rw; size = s; offset = o; zero_ext = z; store_data = sd;
    #1;
    m = exp_mis(s, o);
    checks++;
    if (misaligned !== m) begin
      errors++;
      $display("FAIL R6 misaligned size=%0d off=%0d actual=%0b expected=%0b", s, o, misaligned, m);
    end
    checks++;
    if (load_result !== exp_load(rw, s, o, z)) begin
      errors++;
      $display("FAIL %s load size=%0d off=%0d z=%0b actual=%h expected=%h",
               tag_of(s, z, m), s, o, z, load_result, exp_load(rw, s, o, z));
    end
    checks++;
    if (byte_en !== exp_be(s, o)) begin
      errors++;
      $display("FAIL %s byte_en size=%0d off=%0d actual=%h expected=%h",
               m ? "R7" : "R8", s, o, byte_en, exp_be(s, o));
    end
    checks++;
    if (store_lanes !== exp_st(sd, s)) begin
      errors++;
      $display("FAIL R9 store size=%0d actual=%h expected=%h", s, store_lanes, exp_st(sd, s));
    end
  endtask

  initial begin
    int seed = 32'h5EED_1234;
    void'($urandom(seed));
    #(PERIOD/2 + 1);
    // reset-state: all-zero inputs give byte access at offset 0
    apply(64'd0, 2'd0, 3'd0, 1'b0, 64'd0);
    // R1 sign and zero extension of a negative byte at lane 5
    apply(64'h0011_8022_3344_5566, 2'd0, 3'd5, 1'b0, 64'hA5);
    apply(64'h0011_8022_3344_5566, 2'd0, 3'd5, 1'b1, 64'hA5);
    // R2 negative halfword at offset 6, and a misaligned halfword
    apply(64'hF00D_1234_5678_9ABC, 2'd1, 3'd6, 1'b0, 64'hBEEF);
    apply(64'hF00D_1234_5678_9ABC, 2'd1, 3'd6, 1'b1, 64'hBEEF);
    apply(64'hF00D_1234_5678_9ABC, 2'd1, 3'd3, 1'b0, 64'hBEEF);
    // R3 / R4 word with bit 31 set at offset 4
    apply(64'h8000_0001_7FFF_FFFF, 2'd2, 3'd4, 1'b0, 64'hCAFE_F00D);
    apply(64'h8000_0001_7FFF_FFFF, 2'd2, 3'd4, 1'b1, 64'hCAFE_F00D);
    apply(64'h8000_0001_7FFF_FFFF, 2'd2, 3'd2, 1'b1, 64'hCAFE_F00D);
    // R5 doubleword, both extension settings, and a misaligned doubleword
    apply(64'hFEDC_BA98_7654_3210, 2'd3, 3'd0, 1'b0, 64'h0123_4567_89AB_CDEF);
    apply(64'hFEDC_BA98_7654_3210, 2'd3, 3'd0, 1'b1, 64'h0123_4567_89AB_CDEF);
    apply(64'hFEDC_BA98_7654_3210, 2'd3, 3'd4, 1'b0, 64'h0123_4567_89AB_CDEF);
    // R8 byte at top lane
    apply(64'hFF00_0000_0000_0000, 2'd0, 3'd7, 1'b0, 64'h7E);
    // R10 outputs change with no clock edge between vectors
    for (int i = 0; i < 3000; i++) begin
      apply({$urandom(), $urandom()}, 2'($urandom()), 3'($urandom()), 1'($urandom()),
            {$urandom(), $urandom()});
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule